// File: doc/BRIEF.md
# Matrix Keypad Row-Scan Engine

This block scans a key matrix of up to 16 rows by 8 columns from a slow scan clock. Every general-purpose pin carries two small configuration fields, one saying whether the pin serves as a row (and which one), the other whether it serves as a column (and which one). The engine walks the enabled row numbers in ascending order and pulls each one low in turn. It watches the synchronised column sense lines for the length of a fixed settle period plus a programmable debounce window.

A full scan starts with a fixed lead-in, covers every enabled row, and is followed by a programmable gap before the next scan begins. At the end of each scan the engine emits a one-cycle strobe with a snapshot of up to eight pressed keys. Each key is given as a row number and a column number with a valid flag. A host samples the snapshot on the strobe, so it sees the whole key state once per scan instead of a stream of per-key events.

Top module: `kp_scan_engine`

## Requirements
- R1: While reset is high, and on the first cycle after it, every `drive_n` bit is 1, `snap_valid` is 0 and `snap_key_vld` is 0.
- R2: A pin is driven low only when its row field is enabled and its row number is the row being scanned. Row drive is active-low, and at any time the low pins all carry a single row number.
- R3: The interval between two consecutive `snap_valid` pulses is `rpt_cnt + 5 + N*(16 + D)` clock cycles. N is the number of distinct enabled row numbers and D is the effective debounce count.
- R4: The effective debounce count D is `db_cnt` clamped to 1023. Any larger value behaves exactly like 1023.
- R5: Snapshot entries are filled from slot 0 upward in ascending row order, then ascending column order. Slot i holds its row in `snap_row[4i+3:4i]` and its column in `snap_col[3i+2:3i]`, with `snap_key_vld[i]` set. Unused slots read 0 with their valid bit clear.
- R6: When more than eight keys read pressed in one scan, only the first eight in that order are reported and the rest are dropped.
- R7: A key is reported only if its column reads pressed on every sample of the last D+1 cycles of its row's dwell. A key that bounces during that window is not reported.
- R8: The row field of pin p is `row_cfg[5p+4:5p]`, with enable in bit 0 and the row number in bits 4:1. The column field is `col_cfg[4p+3:4p]`, with enable in bit 0 and the column number in bits 3:1. A column reads pressed when a column pin mapped to it senses 0. Keys on rows that are not enabled are never reported.
- R9: One cycle after `en` is sampled low, every `drive_n` bit is 1 and no `snap_valid` pulse occurs while `en` stays low.
- R10: With no row enabled, each scan is only the lead-in. The engine emits an empty snapshot every `rpt_cnt + 5` cycles.
- R11: `snap_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run the scan; low returns to idle |
| db_cnt | input | DB_IN_W | Debounce count, clamped to 1023 |
| rpt_cnt | input | RPT_W | Gap cycles between scans |
| row_cfg | input | NPIN*5 | Per-pin row field {number, enable} |
| col_cfg | input | NPIN*4 | Per-pin column field {number, enable} |
| sense | input | NPIN | Raw pin sense levels, low = pulled by a key |
| drive_n | output | NPIN | Registered active-low row drive per pin |
| snap_valid | output | 1 | One-cycle strobe: snapshot ready |
| snap_key_vld | output | 8 | Valid flag per snapshot slot |
| snap_row | output | 32 | Row number per slot, 4 bits each |
| snap_col | output | 24 | Column number per slot, 3 bits each |

## Verification
The main function is tried with a single key on the lowest row and column, with scattered keys across several rows, and with more than eight keys at once. It is also tried with only two rows enabled while a key sits on a disabled row, and with no rows enabled at all. Together these separate ordering errors, capacity overflow, row-mask filtering and the empty-scan path. The pin map numbers rows and columns in a different order from the pins themselves, so a design that reports pin order rather than matrix order is exposed. Scan-period measurements for each pattern tell apart the lead-in, dwell, debounce clamp and gap terms, and a bouncing key next to a steady one tests the stability window.

// File: rtl/kp_scan_pkg.sv
package kp_scan_pkg;
  localparam int KP_ROWS   = 16;
  localparam int KP_COLS   = 8;
  localparam int KP_RW     = $clog2(KP_ROWS);
  localparam int KP_CW     = $clog2(KP_COLS);
  localparam int KP_RFW    = KP_RW + 1;
  localparam int KP_CFW    = KP_CW + 1;
  localparam int KP_KEYS   = 8;
  localparam int KP_SETTLE = 16;
  localparam int KP_LEAD   = 5;
  localparam int KP_DB_MAX = 1023;
  localparam int KP_DB_W   = $clog2(KP_DB_MAX + 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_ROW,
    ST_GAP
  } scan_st_e;
endpackage

// File: rtl/kp_sync.sv
module kp_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '1;
      q      <= '1;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/kp_pin_map.sv
module kp_pin_map
  import kp_scan_pkg::*;
#(
  parameter int NPIN = 24
) (
  input  logic [NPIN*KP_RFW-1:0] row_cfg,
  input  logic [NPIN*KP_CFW-1:0] col_cfg,
  input  logic [NPIN-1:0]        sense_s,
  input  logic                   drv_on,
  input  logic [KP_RW-1:0]       drv_row,
  output logic [KP_ROWS-1:0]     row_mask,
  output logic [KP_COLS-1:0]     col_hit,
  output logic [NPIN-1:0]        drive_n_d
);
  logic [NPIN-1:0] is_row;
  logic [NPIN-1:0] is_col;
  logic [KP_RW-1:0] rnum [NPIN];
  logic [KP_CW-1:0] cnum [NPIN];

  // per-pin field decode; a pin with both fields enabled acts as a row
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    assign is_row[p]    = row_cfg[p*KP_RFW];
    assign rnum[p]      = row_cfg[p*KP_RFW+1 +: KP_RW];
    assign is_col[p]    = col_cfg[p*KP_CFW] & ~is_row[p];
    assign cnum[p]      = col_cfg[p*KP_CFW+1 +: KP_CW];
    assign drive_n_d[p] = ~(drv_on & is_row[p] & (rnum[p] == drv_row));
  end

  always_comb begin
    row_mask = '0;
    col_hit  = '0;
    for (int p = 0; p < NPIN; p++) begin
      if (is_row[p]) row_mask[rnum[p]] = 1'b1;
      if (is_col[p] && !sense_s[p]) col_hit[cnum[p]] = 1'b1;
    end
  end
endmodule

// File: rtl/kp_key_collect.sv
module kp_key_collect
  import kp_scan_pkg::*;
#(
  parameter int KEYS = KP_KEYS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clear,
  input  logic                  merge,
  input  logic [KP_RW-1:0]      row,
  input  logic [KP_COLS-1:0]    hits,
  output logic [KEYS-1:0]       ent_vld,
  output logic [KEYS*KP_RW-1:0] ent_row,
  output logic [KEYS*KP_CW-1:0] ent_col
);
  localparam int CNT_W = $clog2(KEYS + 1);

  logic [KP_RW-1:0] rows_q [KEYS];
  logic [KP_CW-1:0] cols_q [KEYS];
  logic [KP_RW-1:0] rows_d [KEYS];
  logic [KP_CW-1:0] cols_d [KEYS];
  logic [KEYS-1:0]  vld_q, vld_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // append pressed columns of this row, lowest column first, until full
  always_comb begin
    int n;
    rows_d = rows_q;
    cols_d = cols_q;
    vld_d  = vld_q;
    n      = int'(cnt_q);
    for (int c = 0; c < KP_COLS; c++) begin
      if (hits[c] && n < KEYS) begin
        rows_d[n] = row;
        cols_d[n] = KP_CW'(c);
        vld_d[n]  = 1'b1;
        n         = n + 1;
      end
    end
    cnt_d = CNT_W'(n);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
      vld_q <= '0;
      for (int i = 0; i < KEYS; i++) begin
        rows_q[i] <= '0;
        cols_q[i] <= '0;
      end
    end else if (merge) begin
      cnt_q  <= cnt_d;
      vld_q  <= vld_d;
      rows_q <= rows_d;
      cols_q <= cols_d;
    end
  end

  assign ent_vld = vld_q;
  for (genvar i = 0; i < KEYS; i++) begin : g_out
    assign ent_row[i*KP_RW +: KP_RW] = rows_q[i];
    assign ent_col[i*KP_CW +: KP_CW] = cols_q[i];
  end
endmodule

// File: rtl/kp_scan_engine.sv
module kp_scan_engine
  import kp_scan_pkg::*;
#(
  parameter int NPIN    = 24,
  parameter int DB_IN_W = 12,
  parameter int RPT_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic [DB_IN_W-1:0]       db_cnt,
  input  logic [RPT_W-1:0]         rpt_cnt,
  input  logic [NPIN*KP_RFW-1:0]   row_cfg,
  input  logic [NPIN*KP_CFW-1:0]   col_cfg,
  input  logic [NPIN-1:0]          sense,
  output logic [NPIN-1:0]          drive_n,
  output logic                     snap_valid,
  output logic [KP_KEYS-1:0]       snap_key_vld,
  output logic [KP_KEYS*KP_RW-1:0] snap_row,
  output logic [KP_KEYS*KP_CW-1:0] snap_col
);
  localparam int DWELL_MAX = KP_SETTLE + KP_DB_MAX;
  localparam int CW_DWELL  = $clog2(DWELL_MAX + 1);
  localparam int CNT_W     = (RPT_W > CW_DWELL) ? RPT_W : CW_DWELL;

  scan_st_e          st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [KP_RW-1:0]  cur_q, cur_n;
  logic [KP_COLS-1:0] acc_q;
  logic              merge, clear, req, req_q;

  logic [NPIN-1:0]    sense_s;
  logic [KP_ROWS-1:0] row_mask;
  logic [KP_COLS-1:0] col_hit;
  logic [NPIN-1:0]    drive_n_d;
  logic [KP_KEYS-1:0]       ent_vld;
  logic [KP_KEYS*KP_RW-1:0] ent_row;
  logic [KP_KEYS*KP_CW-1:0] ent_col;

  logic [KP_DB_W-1:0] db_eff;
  logic [CNT_W-1:0]   dwell_last, gap_last;
  logic [KP_RW-1:0]   first_row, next_row;
  logic               any_row, has_next;

  kp_sync #(.W(NPIN)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (sense),
    .q   (sense_s)
  );

  kp_pin_map #(.NPIN(NPIN)) u_map (
    .row_cfg   (row_cfg),
    .col_cfg   (col_cfg),
    .sense_s   (sense_s),
    .drv_on    (st_n == ST_ROW),
    .drv_row   (cur_n),
    .row_mask  (row_mask),
    .col_hit   (col_hit),
    .drive_n_d (drive_n_d)
  );

  kp_key_collect #(.KEYS(KP_KEYS)) u_keys (
    .clk     (clk),
    .rst     (rst),
    .clear   (clear),
    .merge   (merge),
    .row     (cur_q),
    .hits    (acc_q & col_hit),
    .ent_vld (ent_vld),
    .ent_row (ent_row),
    .ent_col (ent_col)
  );

  // debounce clamp and window ends
  always_comb begin
    if (int'(db_cnt) > KP_DB_MAX) db_eff = KP_DB_W'(KP_DB_MAX);
    else                          db_eff = KP_DB_W'(db_cnt);
    dwell_last = CNT_W'(KP_SETTLE - 1) + CNT_W'(db_eff);
    gap_last   = CNT_W'(rpt_cnt) - CNT_W'(1);
  end

  // lowest enabled row, and lowest enabled row above the current one
  always_comb begin
    first_row = '0;
    next_row  = '0;
    has_next  = 1'b0;
    any_row   = |row_mask;
    for (int r = KP_ROWS - 1; r >= 0; r--) begin
      if (row_mask[r]) begin
        first_row = KP_RW'(r);
        if (r > int'(cur_q)) begin
          next_row = KP_RW'(r);
          has_next = 1'b1;
        end
      end
    end
  end

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    cur_n = cur_q;
    merge = 1'b0;
    clear = 1'b0;
    req   = 1'b0;
    if (!en) begin
      st_n  = ST_IDLE;
      cnt_n = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          st_n  = ST_LEAD;
          cnt_n = '0;
        end
        ST_LEAD: begin
          if (cnt_q >= CNT_W'(KP_LEAD - 1)) begin
            clear = 1'b1;
            cnt_n = '0;
            if (any_row) begin
              st_n  = ST_ROW;
              cur_n = first_row;
            end else begin
              req  = 1'b1;
              st_n = (rpt_cnt == '0) ? ST_LEAD : ST_GAP;
            end
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        ST_ROW: begin
          if (cnt_q >= dwell_last) begin
            merge = 1'b1;
            cnt_n = '0;
            if (has_next) begin
              cur_n = next_row;
            end else begin
              req  = 1'b1;
              st_n = (rpt_cnt == '0) ? ST_LEAD : ST_GAP;
            end
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        ST_GAP: begin
          if (cnt_q >= gap_last) begin
            st_n  = ST_LEAD;
            cnt_n = '0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      cur_q   <= '0;
      acc_q   <= '1;
      req_q   <= 1'b0;
      drive_n <= '1;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      cur_q   <= cur_n;
      req_q   <= req;
      drive_n <= drive_n_d;
      // a column survives only if it reads pressed on every window sample
      if (st_q != ST_ROW || merge)
        acc_q <= '1;
      else if (cnt_q >= CNT_W'(KP_SETTLE - 1))
        acc_q <= acc_q & col_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_valid   <= 1'b0;
      snap_key_vld <= '0;
      snap_row     <= '0;
      snap_col     <= '0;
    end else begin
      snap_valid <= req_q & en;
      if (req_q && en) begin
        snap_key_vld <= ent_vld;
        snap_row     <= ent_row;
        snap_col     <= ent_col;
      end
    end
  end
endmodule

// File: rtl/kp_scan_chk.sv
module kp_scan_chk
  import kp_scan_pkg::*;
#(
  parameter int NPIN    = 24,
  parameter int DB_IN_W = 12,
  parameter int RPT_W   = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     en,
  input logic [DB_IN_W-1:0]       db_cnt,
  input logic [RPT_W-1:0]         rpt_cnt,
  input logic [NPIN*KP_RFW-1:0]   row_cfg,
  input logic [NPIN*KP_CFW-1:0]   col_cfg,
  input logic [NPIN-1:0]          sense,
  input logic [NPIN-1:0]          drive_n,
  input logic                     snap_valid,
  input logic [KP_KEYS-1:0]       snap_key_vld,
  input logic [KP_KEYS*KP_RW-1:0] snap_row,
  input logic [KP_KEYS*KP_CW-1:0] snap_col
);
  // R1: reset leaves outputs idle
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (&drive_n && !snap_valid && snap_key_vld == '0));

  // R2: a pin without an enabled row field is never pulled low
  for (genvar p = 0; p < NPIN; p++) begin : g_r2
    a_r2_unmapped_pin_idle: assert property (@(posedge clk) disable iff (rst)
      !$past(row_cfg[p*KP_RFW]) |-> drive_n[p]);
  end

  // R5: valid flags are packed from slot 0 upward
  a_r5_packed_slots: assert property (@(posedge clk) disable iff (rst)
    snap_valid |-> ((snap_key_vld & (snap_key_vld + 1'b1)) == '0));

  // R9: clearing enable idles the drivers and suppresses snapshots
  a_r9_disable_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> (&drive_n && !snap_valid));

  // R11: snapshot strobe lasts one cycle
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
    snap_valid |=> !snap_valid);
endmodule

bind kp_scan_engine kp_scan_chk #(.NPIN(NPIN), .DB_IN_W(DB_IN_W), .RPT_W(RPT_W)) u_chk (.*);

// File: tb/kp_scan_engine_bench.sv
module kp_scan_engine_bench;
  localparam int NPIN = 24;
  localparam int NV   = 5;

  localparam logic [127:0] VK [NV] = '{
    128'd1,
    (128'd1 << 21) | (128'd1 << 17) | (128'd1 << 79),
    (128'hFF << 24) | (128'h3 << 32) | (128'd1 << 14),
    (128'd1 << 2) | (128'd1 << 43) | (128'd1 << 57),
    (128'd1 << 9)
  };
  localparam logic [15:0] VM [NV] = '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h0021, 16'h0000};
  localparam logic [11:0] VD [NV] = '{12'd0, 12'd4, 12'd1, 12'd2, 12'd0};
  localparam logic [15:0] VR [NV] = '{16'd3, 16'd0, 16'd10, 16'd1, 16'd7};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [11:0] db  = '0;
  logic [15:0] rpt = '0;
  logic [NPIN*5-1:0] rcfg = '0;
  logic [NPIN*4-1:0] ccfg = '0;
  logic [NPIN-1:0] sense, drive_n;
  logic snap_valid;
  logic [7:0]  kv;
  logic [31:0] srow;
  logic [23:0] scol;
  logic [127:0] keys = '0;
  logic bounce_on = 1'b0, bounce_ph = 1'b0;
  int tests = 0, fails = 0, cyc = 0, drv_bad = 0;

  always #4 clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc % 7 == 0) bounce_ph <= ~bounce_ph;
  end

  kp_scan_engine u_kp_scan_engine (
    .clk (clk), .rst (rst), .en (en), .db_cnt (db), .rpt_cnt (rpt),
    .row_cfg (rcfg), .col_cfg (ccfg), .sense (sense), .drive_n (drive_n),
    .snap_valid (snap_valid), .snap_key_vld (kv), .snap_row (srow), .snap_col (scol)
  );

  // key matrix model: a column pin reads 0 when a driven row has a pressed key on it
  always_comb begin
    logic [127:0] keff;
    keff = keys;
    if (bounce_on) keff[3] = bounce_ph;
    for (int p = 0; p < NPIN; p++) begin
      sense[p] = 1'b1;
      if (ccfg[p*4] && !rcfg[p*5]) begin
        for (int q = 0; q < NPIN; q++) begin
          if (rcfg[q*5] && !drive_n[q] &&
              keff[int'(rcfg[q*5+1 +: 4])*8 + int'(ccfg[p*4+1 +: 3])])
            sense[p] = 1'b0;
        end
      end
    end
  end

  // R2 monitor: unmapped pins stay high, low pins share one row number
  always @(negedge clk) begin
    if (!rst) begin
      int seen;
      seen = -1;
      for (int p = 0; p < NPIN; p++) begin
        if (!drive_n[p]) begin
          if (!rcfg[p*5]) drv_bad++;
          else if (seen >= 0 && seen != int'(rcfg[p*5+1 +: 4])) drv_bad++;
          else seen = int'(rcfg[p*5+1 +: 4]);
        end
      end
    end
  end

  function automatic int row_of(int k);
    return (k * 5) % 16;
  endfunction

  // R8 field layout: pins 0..7 are columns 7..0, pins 8..23 rows in a permuted order
  task automatic set_map(input logic [15:0] rm);
    rcfg = '0;
    ccfg = '0;
    for (int p = 0; p < 8; p++) ccfg[p*4 +: 4] = {3'(7 - p), 1'b1};
    for (int k = 0; k < 16; k++)
      if (rm[row_of(k)]) rcfg[(8+k)*5 +: 5] = {4'(row_of(k)), 1'b1};
  endtask

  function automatic logic [63:0] expect_snap(input logic [127:0] k, input logic [15:0] rm);
    logic [7:0] ev; logic [31:0] er; logic [23:0] ec; int n;
    ev = '0; er = '0; ec = '0; n = 0;
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 8; c++)
        if (rm[r] && k[r*8+c] && n < 8) begin
          ev[n] = 1'b1; er[n*4 +: 4] = 4'(r); ec[n*3 +: 3] = 3'(c); n++;
        end
    return {ev, er, ec};
  endfunction

  function automatic int expect_period(input logic [15:0] rm, input logic [11:0] d, input logic [15:0] g);
    int de;
    de = (int'(d) > 1023) ? 1023 : int'(d);
    return int'(g) + 5 + $countones(rm) * (16 + de);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic wait_snap(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!snap_valid);
  endtask

  task automatic start(input logic [15:0] rm, input logic [127:0] k,
                       input logic [11:0] d, input logic [15:0] g);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    set_map(rm); keys = k; db = d; rpt = g;
    @(negedge clk);
    en = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int g;
    repeat (3) @(negedge clk);
    // R1: outputs idle during reset
    chk("R1 reset state", {39'd0, drive_n, snap_valid}, {39'd0, {NPIN{1'b1}}, 1'b0});
    rst = 1'b0;

    // table walk: R3 R5 R6 R8 R10 on each vector
    for (int i = 0; i < NV; i++) begin
      start(VM[i], VK[i], VD[i], VR[i]);
      wait_snap(g);
      chk($sformatf("R5 R6 R8 R10 vector %0d entries", i), {kv, srow, scol}, expect_snap(VK[i], VM[i]));
      wait_snap(g);
      chk($sformatf("R3 R10 vector %0d period", i), 64'(g), 64'(expect_period(VM[i], VD[i], VR[i])));
    end

    // R4: debounce above 1023 behaves as 1023
    start(16'h0001, 128'd1 << 6, 12'hFFF, 16'd0);
    wait_snap(g);
    chk("R4 clamped debounce entries", {kv, srow, scol}, expect_snap(128'd1 << 6, 16'h0001));
    wait_snap(g);
    chk("R4 clamped debounce period", 64'(g), 64'(5 + 16 + 1023));

    // R7: bouncing key (row 0, col 3) dropped, steady key (row 0, col 5) kept
    start(16'h0001, 128'd1 << 5, 12'd40, 16'd0);
    bounce_on = 1'b1;
    wait_snap(g);
    wait_snap(g);
    chk("R7 bouncing key rejected", {kv, srow, scol}, expect_snap(128'd1 << 5, 16'h0001));
    bounce_on = 1'b0;

    // R9: clearing enable idles drivers at once and stops snapshots
    start(16'hFFFF, 128'd1, 12'd0, 16'd0);
    repeat (40) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R9 drivers idle after disable", 64'(drive_n), 64'({NPIN{1'b1}}));
    begin
      int seen;
      seen = 0;
      repeat (400) begin
        @(negedge clk);
        if (snap_valid || !(&drive_n)) seen++;
      end
      chk("R9 quiet while disabled", 64'(seen), 64'd0);
    end

    // R11: strobe width
    start(16'h0003, 128'd1, 12'd0, 16'd0);
    wait_snap(g);
    @(negedge clk);
    chk("R11 strobe single cycle", 64'(snap_valid), 64'd0);

    chk("R2 row drive discipline", 64'(drv_bad), 64'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule